// File: doc/BRIEF.md
# Byte-Stream Frame Alignment Monitor

This block watches a receive stream that has already been cut into bytes from a 2.488 Gb/s optical line signal. While it is hunting, it looks at every accepted byte position for a six-byte slice of the frame-alignment pattern. That slice is three 0xF6 bytes followed by three 0x28 bytes. When it finds the slice, it locks onto that position. A byte counter then predicts where the slice will come back one frame later.

While locked, the block compares the slice at the predicted position once per frame. Every such comparison produces a frame-start pulse. A mismatch in any bit of the slice also raises a per-frame error flag. Four errored frames in a row raise the severely-errored-frame alarm, drop the lock and restart the hunt. The alarm stays up until two clean frames in a row are seen after the block locks again. The frame length is a parameter, so a bench can use short frames.

Top module: `frm_align_mon`

## Requirements
- R1: A synchronous reset makes `in_frame`, `frm_start`, `frm_err` and `sef_alarm` low from the cycle after reset.
- R2: While hunting, the block accepts the six-byte slice F6 F6 F6 28 28 28 at any byte position. In the cycle after the last slice byte it raises `in_frame` and pulses `frm_start`, without `frm_err`.
- R3: While locked, `frm_start` pulses exactly once every `FRAME_LEN` accepted bytes. The pulse comes in the cycle after the byte that ends the predicted slice, and at no other byte.
- R4: At each locked check, `frm_err` pulses together with `frm_start` if any bit of the six slice bytes differs from the expected pattern. It stays low when all six bytes match.
- R5: On the fourth consecutive errored check, `sef_alarm` rises and `in_frame` falls in the same cycle, and the hunt restarts.
- R6: A clean locked check clears the run of errored frames, so three errors, one clean frame and three more errors do not raise `sef_alarm`.
- R7: After the block locks again, `sef_alarm` stays high until two consecutive clean checks. It falls in the cycle after the second one.
- R8: A cycle with `rx_valid` low advances neither the frame counter nor the slice search. Its data byte is not seen, so idle cycles inside a frame do not move the check position, and a slice shown only on idle cycles does not lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | High when `rx_data` holds a byte to accept |
| in_frame | output | 1 | High while locked to a frame boundary |
| frm_start | output | 1 | One-cycle pulse at each slice position found or checked |
| frm_err | output | 1 | One-cycle pulse when the checked slice has a bit error |
| sef_alarm | output | 1 | Severely-errored-frame alarm |

## Verification
The hardest state to reach from the ports is the alarm-clear path. To get there, the block must first take four errored frames in a row, then lose lock, hunt, lock again, and only then count clean frames. The stimulus table drives whole frames, each with a chosen byte and bit mask to corrupt. The table walks through a broken run that a clean frame interrupts, then an unbroken run of four errors, then a corrupted slice while hunting that must not lock, then a relock and two clean frames. Idle cycles are mixed into frames afterwards, to show that the check position does not move.

// File: rtl/frm_pkg.sv
package frm_pkg;

    localparam logic [7:0] SYNC_A1 = 8'hF6;
    localparam logic [7:0] SYNC_A2 = 8'h28;

    localparam int unsigned HALF_WIN  = 3;
    localparam int unsigned WIN_BYTES = 2 * HALF_WIN;

    localparam int unsigned ERR_LIMIT   = 4;
    localparam int unsigned CLEAN_LIMIT = 2;
    localparam int unsigned ERR_W   = (ERR_LIMIT > 1) ? $clog2(ERR_LIMIT) : 1;
    localparam int unsigned CLEAN_W = (CLEAN_LIMIT > 1) ? $clog2(CLEAN_LIMIT) : 1;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } align_state_t;

    typedef struct packed {
        logic start;
        logic err;
    } frame_evt_t;

    function automatic logic [7:0] expected_byte(input int unsigned idx);
        return (idx < HALF_WIN) ? SYNC_A1 : SYNC_A2;
    endfunction

endpackage

// File: rtl/frm_win_cmp.sv
module frm_win_cmp
    import frm_pkg::*;
#(
    parameter int unsigned WIN = WIN_BYTES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] byte_in,
    input  logic       valid,
    output logic       hit
);
    logic [WIN-2:0][7:0] hist;
    logic [WIN-1:0][7:0] cand;
    logic [WIN-1:0]      eq;

    genvar g;
    generate
        for (g = 0; g < WIN; g++) begin : g_lane
            if (g == WIN - 1) begin : g_new
                assign cand[g] = byte_in;
            end else begin : g_old
                assign cand[g] = hist[g];
            end
            assign eq[g] = (cand[g] == expected_byte(g));
        end
    endgenerate

    assign hit = &eq;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (valid) begin
            for (int k = 0; k < WIN - 1; k++) begin
                hist[k] <= cand[k+1];
            end
        end
    end

    p_search_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(hist));

endmodule

// File: rtl/frm_pos_ctr.sv
module frm_pos_ctr #(
    parameter int unsigned FRAME_LEN = 38880
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic load,
    output logic at_mark
);
    localparam int unsigned CW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam logic [CW-1:0] LAST     = CW'(FRAME_LEN - 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(1 % FRAME_LEN);

    logic [CW-1:0] pos;

    assign at_mark = (pos == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (adv) begin
            if (load) begin
                pos <= LOAD_VAL;
            end else if (pos == LAST) begin
                pos <= '0;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    p_pos_range_r3: assert property (@(posedge clk) disable iff (rst)
        pos <= LAST);

    p_pos_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(pos));

endmodule

// File: rtl/frm_align_fsm.sv
module frm_align_fsm
    import frm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic hit,
    input  logic at_mark,
    output logic load,
    output logic in_frame,
    output logic frm_start,
    output logic frm_err,
    output logic sef_alarm
);
    align_state_t       state;
    frame_evt_t         evt;
    logic [ERR_W-1:0]   err_cnt;
    logic [CLEAN_W-1:0] clean_cnt;
    logic               acq, chk, bad;

    assign acq  = (state == ST_HUNT) && valid && hit;
    assign chk  = (state == ST_LOCK) && valid && at_mark;
    assign bad  = chk && !hit;
    assign load = acq;

    assign in_frame  = (state == ST_LOCK);
    assign frm_start = evt.start;
    assign frm_err   = evt.err;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            evt       <= '0;
            err_cnt   <= '0;
            clean_cnt <= '0;
            sef_alarm <= 1'b0;
        end else begin
            evt.start <= acq || chk;
            evt.err   <= bad;
            if (acq) begin
                state     <= ST_LOCK;
                err_cnt   <= '0;
                clean_cnt <= '0;
            end else if (chk) begin
                if (bad) begin
                    clean_cnt <= '0;
                    if (err_cnt == ERR_W'(ERR_LIMIT - 1)) begin
                        sef_alarm <= 1'b1;
                        state     <= ST_HUNT;
                        err_cnt   <= '0;
                    end else begin
                        err_cnt <= err_cnt + 1'b1;
                    end
                end else begin
                    err_cnt <= '0;
                    if (sef_alarm) begin
                        if (clean_cnt == CLEAN_W'(CLEAN_LIMIT - 1)) begin
                            sef_alarm <= 1'b0;
                            clean_cnt <= '0;
                        end else begin
                            clean_cnt <= clean_cnt + 1'b1;
                        end
                    end
                end
            end
        end
    end

    p_err_with_start_r4: assert property (@(posedge clk) disable iff (rst)
        frm_err |-> frm_start);

    p_alarm_drops_lock_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sef_alarm) |-> (!in_frame && frm_err));

    p_lock_with_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(in_frame) |-> (frm_start && !frm_err));

    p_alarm_clear_clean_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(sef_alarm) |-> (in_frame && frm_start && !frm_err));

    p_run_reset_r6: assert property (@(posedge clk) disable iff (rst)
        (frm_start && !frm_err) |-> (err_cnt == '0));

endmodule

// File: rtl/frm_align_mon.sv
module frm_align_mon
    import frm_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 38880
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] rx_data,
    input  logic       rx_valid,
    output logic       in_frame,
    output logic       frm_start,
    output logic       frm_err,
    output logic       sef_alarm
);
    logic win_hit;
    logic at_mark;
    logic ctr_load;

    frm_win_cmp #(.WIN(WIN_BYTES)) u_win (
        .clk     (clk),
        .rst     (rst),
        .byte_in (rx_data),
        .valid   (rx_valid),
        .hit     (win_hit)
    );

    frm_pos_ctr #(.FRAME_LEN(FRAME_LEN)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .adv     (rx_valid),
        .load    (ctr_load),
        .at_mark (at_mark)
    );

    frm_align_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .valid     (rx_valid),
        .hit       (win_hit),
        .at_mark   (at_mark),
        .load      (ctr_load),
        .in_frame  (in_frame),
        .frm_start (frm_start),
        .frm_err   (frm_err),
        .sef_alarm (sef_alarm)
    );

endmodule

// File: tb/frm_align_mon_tb.sv
module frm_align_mon_tb_top;

    localparam int unsigned FL = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_data = '0;
    logic       rx_valid = 1'b0;
    logic       in_frame, frm_start, frm_err, sef_alarm;

    int n_run  = 0;
    int n_fail = 0;
    int spurious = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    frm_align_mon #(.FRAME_LEN(FL)) dut_i (
        .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
        .in_frame(in_frame), .frm_start(frm_start),
        .frm_err(frm_err), .sef_alarm(sef_alarm)
    );

    typedef struct packed {
        logic [2:0] idx;
        logic [7:0] mask;
        logic       st;
        logic       er;
        logic       sf;
        logic       fi;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1},
        '{3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1},
        '{3'd0, 8'h01, 1'b1, 1'b1, 1'b0, 1'b1},
        '{3'd2, 8'h80, 1'b1, 1'b1, 1'b0, 1'b1},
        '{3'd3, 8'h10, 1'b1, 1'b1, 1'b0, 1'b1},
        '{3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1},
        '{3'd5, 8'h80, 1'b1, 1'b1, 1'b0, 1'b1},
        '{3'd4, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1},
        '{3'd1, 8'h02, 1'b1, 1'b1, 1'b0, 1'b1},
        '{3'd3, 8'h01, 1'b1, 1'b1, 1'b1, 1'b0},
        '{3'd0, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0},
        '{3'd0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
        '{3'd0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
        '{3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1},
        '{3'd5, 8'h80, 1'b1, 1'b1, 1'b0, 1'b1},
        '{3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1}
    };

    function automatic string req_of(input int k);
        case (k)
            0, 11:     return "R2";
            1, 15:     return "R3";
            2, 3, 4, 14: return "R4";
            5, 6, 7, 8: return "R6";
            9, 10:     return "R5";
            default:   return "R7";
        endcase
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] b, input logic v);
        @(negedge clk);
        rx_data  = b;
        rx_valid = v;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] frame_byte(input int i);
        if (i < 3) return 8'hF6;
        if (i < 6) return 8'h28;
        return 8'h5A + 8'(i);
    endfunction

    // Sends one frame; slice ends at byte 5. Samples outputs after byte 5.
    task automatic send_frame(input int idx, input logic [7:0] mask, input bit gaps,
                              output logic [3:0] seen);
        seen = '0;
        for (int i = 0; i < FL; i++) begin
            logic [7:0] b;
            b = frame_byte(i);
            if (i == idx) b = b ^ mask;
            if (gaps && (i % 2 == 1)) begin
                drive(8'hF6, 1'b0);
                if (frm_start) spurious++;
            end
            drive(b, 1'b1);
            if (i == 5) seen = {frm_start, frm_err, sef_alarm, in_frame};
            else if (frm_start) spurious++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] seen;
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk) rst = 1'b0;
        #1;
        check(in_frame,  1'b0, "R1 in_frame");
        check(frm_start, 1'b0, "R1 frm_start");
        check(frm_err,   1'b0, "R1 frm_err");
        check(sef_alarm, 1'b0, "R1 sef_alarm");

        for (int k = 0; k < 16; k++) begin
            send_frame(int'(VECS[k].idx), VECS[k].mask, 1'b0, seen);
            check(seen[3], VECS[k].st, $sformatf("%s vec%0d frm_start", req_of(k), k));
            check(seen[2], VECS[k].er, $sformatf("%s vec%0d frm_err", req_of(k), k));
            check(seen[1], VECS[k].sf, $sformatf("%s vec%0d sef_alarm", req_of(k), k));
            check(seen[0], VECS[k].fi, $sformatf("%s vec%0d in_frame", req_of(k), k));
        end
        // R3: no pulses away from the predicted slice end
        check(spurious == 0, 1'b1, "R3 no stray frm_start");

        // R8: idle cycles inside a frame keep alignment
        send_frame(0, 8'h00, 1'b1, seen);
        check(seen[3], 1'b1, "R8 gapped frame start");
        check(seen[2], 1'b0, "R8 gapped frame clean");
        send_frame(0, 8'h00, 1'b0, seen);
        check(seen[3], 1'b1, "R8 alignment kept after gaps");
        check(spurious == 0, 1'b1, "R8 no start on idle cycles");

        // R1: reset while locked
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk) rst = 1'b0;
        #1;
        check(in_frame, 1'b0, "R1 reset drops lock");

        // R8: slice shown only on idle cycles is ignored
        for (int i = 0; i < 6; i++) drive(frame_byte(i), 1'b0);
        drive(8'h00, 1'b0);
        check(in_frame, 1'b0, "R8 idle slice ignored");

        // R8 / R2: slice bytes split by idle cycles still lock
        for (int i = 0; i < 6; i++) begin
            drive(8'h28, 1'b0);
            drive(frame_byte(i), 1'b1);
        end
        check(frm_start, 1'b1, "R2 gapped slice start");
        check(in_frame,  1'b1, "R8 gapped slice locks");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule